// File: doc/BRIEF.md
# DDR SDRAM Power-up Command Sequencer

This block brings a DDR1 or DDR2 SDRAM from power-up to a usable state without any software involvement. After reset it steps through a fixed script of precharge-all, auto-refresh and mode-register load commands, presented one per pulse on a small command/address port that a downstream command path turns into pin activity. Between two commands it holds off for a minimum number of cycles, and that number depends on the class of the command just issued: a mode-register load, a precharge or a refresh.

Two strap inputs are captured while reset is asserted. One chooses the DDR2 or the DDR1 script. The other states whether the reference clock runs at 40 MHz or at 25 MHz, and this sets the refresh interval. When the script has finished, the block publishes a refresh configuration word, starts an internal interval timer that requests an auto-refresh each time it expires, and raises `init_done`.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: `cmd_code` is one-hot while `cmd_valid` is high and zero otherwise. Bit 0 is an MR load, bit 1 an EMR load, bit 2 an auto-refresh, bit 3 a precharge-all, bit 4 an EMR2 load and bit 5 an EMR3 load.
- R2: With the DDR2 strap high, the commands are: precharge-all, EMR2 with 0, EMR3 with 0, EMR with 0, MR with 0x100, precharge-all, auto-refresh, auto-refresh, MR with 0xA33, EMR with 0x382, EMR with 0x402. Refresh and precharge commands carry address 0.
- R3: With the DDR2 strap low, the commands are: precharge-all, MR with 0x133, EMR with 0x002, precharge-all, MR with 0x033.
- R4: Each command is a one-cycle pulse. The next command follows W+1 cycles after the previous one, where W is T_MRD after any mode-register load, T_RP after a precharge and T_RFC after an auto-refresh.
- R5: During reset every output is zero. The first command appears in the first cycle after reset is released.
- R6: `refresh_word` is zero until refresh is enabled. After that it holds bit 14 set, bits 9:0 equal to 624 for a 40 MHz reference or 390 for a 25 MHz reference, and all other bits clear.
- R7: `refresh_en` rises W+1 cycles after the last command, where W belongs to that last command. `init_done` rises one cycle later and stays high until reset. No command follows.
- R8: `refresh_req` is a one-cycle pulse. The first pulse comes interval+1 cycles after `refresh_en` rises, and further pulses follow every interval+1 cycles.
- R9: Both straps are captured only while reset is asserted. Strap changes after reset has been released change neither the script nor the refresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| strap_ddr2 | input | 1 | 1 selects the DDR2 script, 0 selects the DDR1 script |
| strap_ref40 | input | 1 | 1 for a 40 MHz reference, 0 for a 25 MHz reference |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 6 | One-hot command kind |
| cmd_addr | output | ADDR_W | Mode value for register loads, 0 otherwise |
| refresh_en | output | 1 | Periodic refresh enabled |
| refresh_word | output | 16 | Enable flag at bit 14, interval in bits 9:0 |
| refresh_req | output | 1 | Periodic auto-refresh request pulse |
| init_done | output | 1 | Initialisation complete, sticky until reset |

## Verification
All four strap combinations are run as directed cases. Comparing them separates the two scripts by order and by mode value, and separates the two refresh periods through the pulse spacing after enable. Further runs pick the straps at random and then change both strap pins on every cycle after reset. These runs show whether a strap is read outside reset, which would alter the script, the refresh word or the period. Every cycle is compared against a schedule computed from the per-class wait values, so a spacing error on any single command is caught.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

   localparam int CODE_W   = 6;
   localparam int VAL_W    = 16;
   localparam int IDX_W    = 4;
   localparam int LEN_DDR1 = 5;
   localparam int LEN_DDR2 = 11;

   localparam logic [CODE_W-1:0] K_MR   = 6'b000001;
   localparam logic [CODE_W-1:0] K_EMR  = 6'b000010;
   localparam logic [CODE_W-1:0] K_REF  = 6'b000100;
   localparam logic [CODE_W-1:0] K_PRE  = 6'b001000;
   localparam logic [CODE_W-1:0] K_EMR2 = 6'b010000;
   localparam logic [CODE_W-1:0] K_EMR3 = 6'b100000;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [VAL_W-1:0]  val;
   } step_t;

   typedef enum logic [1:0] {
      ST_ISSUE = 2'd0,
      ST_WAIT  = 2'd1,
      ST_DONE  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/seq_script.sv
module seq_script
   import ddr_seq_pkg::*;
(
   input  logic             ddr2,
   input  logic [IDX_W-1:0] idx,
   output step_t            step,
   output logic [IDX_W-1:0] len
);

   always_comb begin
      step = '0;
      if (ddr2) begin
         len = IDX_W'(LEN_DDR2);
         unique case (idx)
            4'd0:    step = '{K_PRE,  16'h0000};
            4'd1:    step = '{K_EMR2, 16'h0000};
            4'd2:    step = '{K_EMR3, 16'h0000};
            4'd3:    step = '{K_EMR,  16'h0000};
            4'd4:    step = '{K_MR,   16'h0100};
            4'd5:    step = '{K_PRE,  16'h0000};
            4'd6:    step = '{K_REF,  16'h0000};
            4'd7:    step = '{K_REF,  16'h0000};
            4'd8:    step = '{K_MR,   16'h0A33};
            4'd9:    step = '{K_EMR,  16'h0382};
            4'd10:   step = '{K_EMR,  16'h0402};
            default: step = '0;
         endcase
      end else begin
         len = IDX_W'(LEN_DDR1);
         unique case (idx)
            4'd0:    step = '{K_PRE, 16'h0000};
            4'd1:    step = '{K_MR,  16'h0133};
            4'd2:    step = '{K_EMR, 16'h0002};
            4'd3:    step = '{K_PRE, 16'h0000};
            4'd4:    step = '{K_MR,  16'h0033};
            default: step = '0;
         endcase
      end
   end

endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer
   import ddr_seq_pkg::*;
#(
   parameter int T_MRD = 4,
   parameter int T_RP  = 6,
   parameter int T_RFC = 30,
   localparam int MAXW  = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                         : ((T_RP > T_MRD) ? T_RP : T_MRD),
   localparam int CNT_W = $clog2(MAXW + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   output logic              expired
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] start;

   always_comb begin
      if (code == K_PRE)      start = CNT_W'(T_RP - 1);
      else if (code == K_REF) start = CNT_W'(T_RFC - 1);
      else                    start = CNT_W'(T_MRD - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= start;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
   parameter int REF_W = 10
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [REF_W-1:0] interval,
   output logic             req
);

   logic [REF_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         req <= 1'b0;
      end else if (!en) begin
         cnt <= interval;
         req <= 1'b0;
      end else if (cnt == '0) begin
         cnt <= interval;
         req <= 1'b1;
      end else begin
         cnt <= cnt - 1'b1;
         req <= 1'b0;
      end
   end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
   import ddr_seq_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int REF_W   = 10,
   parameter int T_MRD   = 4,
   parameter int T_RP    = 6,
   parameter int T_RFC   = 30,
   parameter int REF_25M = 390,
   parameter int REF_40M = 624
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_ddr2,
   input  logic              strap_ref40,
   output logic              cmd_valid,
   output logic [5:0]        cmd_code,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              refresh_en,
   output logic [15:0]       refresh_word,
   output logic              refresh_req,
   output logic              init_done
);

   localparam int EN_BIT = 14;

   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must hold a 12-bit mode value");
   end
   if (REF_W < 1 || REF_W > EN_BIT) begin : g_bad_refw
      $error("REF_W must lie between 1 and 14");
   end
   if (T_MRD < 1 || T_RP < 1 || T_RFC < 1) begin : g_bad_wait
      $error("wait counts must be at least 1");
   end
   if (REF_25M < 1 || REF_40M < 1 || REF_25M >= (1 << REF_W) || REF_40M >= (1 << REF_W))
   begin : g_bad_ref
      $error("refresh intervals must fit REF_W and be non-zero");
   end

   logic             mode_ddr2, mode_r40;
   seq_state_e       state;
   logic [IDX_W-1:0] idx, len;
   step_t            step;
   logic             gap_load, gap_done;
   logic [REF_W-1:0] interval;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_ddr2 <= strap_ddr2;
         mode_r40  <= strap_ref40;
      end
   end

   seq_script u_script (
      .ddr2 (mode_ddr2),
      .idx  (idx),
      .step (step),
      .len  (len)
   );

   assign gap_load = (state == ST_ISSUE) && (idx != len);

   seq_gap_timer #(.T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gap_load),
      .code    (step.code),
      .expired (gap_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_ISSUE;
         idx        <= '0;
         cmd_valid  <= 1'b0;
         cmd_code   <= '0;
         cmd_addr   <= '0;
         refresh_en <= 1'b0;
         init_done  <= 1'b0;
      end else begin
         unique case (state)
            ST_ISSUE: begin
               if (idx == len) begin
                  refresh_en <= 1'b1;
                  state      <= ST_DONE;
               end else begin
                  cmd_valid <= 1'b1;
                  cmd_code  <= step.code;
                  cmd_addr  <= step.val[ADDR_W-1:0];
                  idx       <= idx + 1'b1;
                  state     <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               cmd_valid <= 1'b0;
               cmd_code  <= '0;
               cmd_addr  <= '0;
               if (gap_done) state <= ST_ISSUE;
            end
            ST_DONE: init_done <= 1'b1;
            default: state <= ST_DONE;
         endcase
      end
   end

   assign interval = mode_r40 ? REF_W'(REF_40M) : REF_W'(REF_25M);

   always_comb begin
      refresh_word = '0;
      if (refresh_en) begin
         refresh_word[REF_W-1:0] = interval;
         refresh_word[EN_BIT]    = 1'b1;
      end
   end

   seq_refresh_timer #(.REF_W(REF_W)) u_refresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (refresh_en),
      .interval (interval),
      .req      (refresh_req)
   );

endmodule

// File: rtl/ddr_pwrup_chk.sv
module ddr_pwrup_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic [5:0]  cmd_code,
   input logic        refresh_en,
   input logic [15:0] refresh_word,
   input logic        refresh_req,
   input logic        init_done
);

   p_onehot_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $countones(cmd_code) == 1);

   p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> cmd_code == 6'd0);

   p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_en |=> $stable(refresh_word));

   p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_en && !init_done) |=> init_done);

   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   p_quiet_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_en |-> !cmd_valid);

   p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |=> !refresh_req);

   p_req_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> refresh_en);

endmodule

bind ddr_pwrup_seq ddr_pwrup_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_code     (cmd_code),
   .refresh_en   (refresh_en),
   .refresh_word (refresh_word),
   .refresh_req  (refresh_req),
   .init_done    (init_done)
);

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;

   localparam int CLK_P   = 10;
   localparam int ADDR_W  = 13;
   localparam int T_MRD   = 4;
   localparam int T_RP    = 6;
   localparam int T_RFC   = 30;
   localparam int REF_25M = 390;
   localparam int REF_40M = 624;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              strap_ddr2 = 1'b0;
   logic              strap_ref40 = 1'b0;
   logic              cmd_valid;
   logic [5:0]        cmd_code;
   logic [ADDR_W-1:0] cmd_addr;
   logic              refresh_en;
   logic [15:0]       refresh_word;
   logic              refresh_req;
   logic              init_done;

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #(CLK_P/2) clk = ~clk;

   ddr_pwrup_seq #(
      .ADDR_W(ADDR_W), .REF_W(10), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC),
      .REF_25M(REF_25M), .REF_40M(REF_40M)
   ) dut (
      .clk(clk), .rst_n(rst_n), .strap_ddr2(strap_ddr2), .strap_ref40(strap_ref40),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .refresh_en(refresh_en), .refresh_word(refresh_word),
      .refresh_req(refresh_req), .init_done(init_done)
   );

   function automatic int script_len(bit d2);
      return d2 ? 11 : 5;
   endfunction

   // code bits: 0 MR, 1 EMR, 2 refresh, 3 precharge, 4 EMR2, 5 EMR3
   function automatic logic [5:0] script_code(bit d2, int i);
      logic [5:0] d2c [11] = '{6'h08, 6'h10, 6'h20, 6'h02, 6'h01, 6'h08,
                              6'h04, 6'h04, 6'h01, 6'h02, 6'h02};
      logic [5:0] d1c [5]  = '{6'h08, 6'h01, 6'h02, 6'h08, 6'h01};
      return d2 ? d2c[i] : d1c[i];
   endfunction

   function automatic logic [15:0] script_val(bit d2, int i);
      logic [15:0] d2v [11] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h100, 16'h0,
                               16'h0, 16'h0, 16'hA33, 16'h382, 16'h402};
      logic [15:0] d1v [5]  = '{16'h0, 16'h133, 16'h002, 16'h0, 16'h033};
      return d2 ? d2v[i] : d1v[i];
   endfunction

   function automatic int gap_of(logic [5:0] c);
      if (c == 6'h08) return T_RP;
      if (c == 6'h04) return T_RFC;
      return T_MRD;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   task automatic run_case(bit d2, bit r40, bit jitter);
      int len, fin, nxt, idx, ival, last;
      logic [15:0] wexp;
      bit ev, een, edn, erq;
      logic [5:0] ec;
      logic [15:0] ea;
      strap_ddr2  = d2;
      strap_ref40 = r40;
      rst_n       = 1'b0;
      repeat (3) @(negedge clk);
      // R5: reset state
      check({cmd_valid, cmd_code, cmd_addr, refresh_en, refresh_word, refresh_req, init_done} == '0,
            "R5", {31'd0, cmd_valid | refresh_en | init_done | refresh_req}, 32'd0);
      len  = script_len(d2);
      ival = r40 ? REF_40M : REF_25M;
      fin  = 1;
      for (int i = 0; i < len; i++) fin += gap_of(script_code(d2, i)) + 1;
      last = fin + 2 * (ival + 1) + 3;
      rst_n = 1'b1;
      idx = 0;
      nxt = 1;
      for (int t = 1; t <= last; t++) begin
         @(negedge clk);
         ev  = (idx < len) && (t == nxt);
         ec  = ev ? script_code(d2, idx) : 6'h0;
         ea  = ev ? script_val(d2, idx) : 16'h0;
         een = (t >= fin);
         edn = (t >= fin + 1);
         erq = (t > fin) && (((t - fin) % (ival + 1)) == 0);
         wexp = een ? (16'h4000 | 16'(ival)) : 16'h0;
         check(cmd_valid == ev, (t == 1) ? "R5" : "R4", {31'd0, cmd_valid}, {31'd0, ev});
         if (ev)
            check(cmd_code == ec && 16'(cmd_addr) == ea, d2 ? "R2" : "R3",
                  {10'd0, cmd_code, 16'(cmd_addr)}, {10'd0, ec, ea});
         else
            check(cmd_code == 6'h0, "R1", {26'd0, cmd_code}, 32'd0);
         check(refresh_en == een && init_done == edn, "R7",
               {30'd0, refresh_en, init_done}, {30'd0, een, edn});
         check(refresh_word == wexp, jitter ? "R9" : "R6", {16'd0, refresh_word}, {16'd0, wexp});
         check(refresh_req == erq, "R8", {31'd0, refresh_req}, {31'd0, erq});
         if (ev) begin
            nxt = t + gap_of(ec) + 1;
            idx++;
         end
         if (jitter) begin
            strap_ddr2  = 1'($urandom);
            strap_ref40 = 1'($urandom);
         end
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R7 watchdog: sequence did not finish, actual %0d expected below 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int seed_init;
      seed_init = $urandom(32'd4242);
      run_case(1'b1, 1'b0, 1'b0);
      run_case(1'b1, 1'b1, 1'b0);
      run_case(1'b0, 1'b0, 1'b0);
      run_case(1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 4; k++) run_case(1'($urandom), 1'($urandom), 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule